// File: doc/BRIEF.md
# 24-bit Effective Address Generator

This block turns an addressing-mode code plus the current register context into a 24-bit effective address for a processor with a 16-bit word, an 8-bit bank byte and a selectable index width. A request carries the mode code, up to three operand bytes and a snapshot of the direct page, data bank, program bank, X, Y and stack pointer registers. It also carries the index-width flag and an access-type flag that marks control transfers. Direct modes produce the address in the cycle after the request is taken. Indirect modes first read a 2- or 3-byte pointer through a byte-read port and then combine that pointer with a bank byte and, for the post-indexed forms, the Y register.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` drops for the whole of a pointer fetch, so a held request simply waits. The request fields are sampled only on the accepting edge. The read side is plain: `rd_req` and `rd_addr` stay steady until the memory answers with `rd_ack` and `rd_data` in the same cycle, and the memory may stall for any number of cycles. The result appears on `ea` together with a one-cycle `done` pulse. `req_ready` is high again during that pulse, so requests can be issued back to back.

Top module: `eaddr_gen`

## Requirements
- R1: Mode 0 (absolute) gives {bank, operand[15:0]}, where the bank is the program bank when `ctrl_access` is 1 and the data bank otherwise. `done` rises in the cycle after acceptance. Codes 17 to 31 behave as code 0.
- R2: Mode 3 (long) gives operand[23:0]. Mode 4 (long, X) gives operand[23:0] plus X, modulo 2^24.
- R3: Mode 1 (absolute, X) and mode 2 (absolute, Y) give {data bank, operand[15:0]} plus the index, modulo 2^24, so a carry reaches the bank byte.
- R4: When `idx_narrow` is 1, every X or Y contribution uses only the index's low 8 bits, with a zero high byte.
- R5: Modes 5, 6 and 7 (direct page, plain / +X / +Y) give {0x00, (direct page + operand[7:0] [+ index]) mod 2^16}.
- R6: Mode 8 reads a 16-bit pointer at {0x00, direct page + operand[7:0]} and gives {data bank, pointer}. Mode 9 adds Y to that value, modulo 2^24. Mode 10 reads the pointer at {0x00, direct page + operand[7:0] + X} and gives {data bank, pointer}.
- R7: Mode 11 reads a 24-bit pointer at {0x00, direct page + operand[7:0]} and gives it unchanged. Mode 12 adds Y to it, modulo 2^24.
- R8: Mode 13 reads a 16-bit pointer at {0x00, operand[15:0]} and gives {program bank, pointer}. Mode 14 reads the pointer at {program bank, (operand[15:0] + X) mod 2^16} and gives {program bank, pointer}. Mode 15 reads a 24-bit pointer at {0x00, operand[15:0]}.
- R9: Mode 16 reads a 16-bit pointer at {0x00, (stack pointer + operand[7:0]) mod 2^16} and gives {data bank, pointer} plus Y, modulo 2^24.
- R10: Pointer bytes are read low byte first, one byte per `rd_ack`. Each later byte sits at the previous address plus one within the same bank, and the low 16 bits wrap from 0xFFFF to 0x0000. `rd_addr` stays steady while `rd_req` waits for `rd_ack`.
- R11: For an indirect mode, `done` is high for exactly one cycle, in the cycle after the last pointer byte is acknowledged, and `ea` holds the result while `done` is high.
- R12: `req_ready` is low from the cycle after an indirect request is taken until the `done` cycle. Changes to request inputs while `req_ready` is low do not affect the result.
- R13: While reset is held, `req_ready` is 1, `done` is 0 and `rd_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request may be taken |
| mode | input | 5 | Addressing-mode code (0 to 16) |
| operand | input | 24 | Operand bytes, first byte in bits 7:0 |
| dp_reg | input | 16 | Direct page register |
| dbank | input | 8 | Data bank register |
| pbank | input | 8 | Program bank register |
| x_reg | input | 16 | X index register |
| y_reg | input | 16 | Y index register |
| sp_reg | input | 16 | Stack pointer |
| idx_narrow | input | 1 | 1 = index registers are 8 bits wide |
| ctrl_access | input | 1 | 1 = control transfer, 0 = data access |
| rd_req | output | 1 | Pointer byte read request |
| rd_addr | output | 24 | Pointer byte address |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | 8 | Pointer byte |
| ea | output | 24 | Effective address |
| done | output | 1 | One-cycle pulse, `ea` valid |

## Verification
The bench aims at the carry boundaries. An indexed absolute sum must spill into the bank byte, while a direct-page sum must stay inside bank zero. A design that wrapped the wrong one would return an address off by 0x010000. Pointer reads that start at 0xFFFF must continue at 0x0000 in the same bank; a design that carried would fetch the high byte from the wrong bank. The jump-indexed-indirect mode reads from the program bank rather than bank zero. Narrow-index requests use registers with non-zero high bytes, so an untruncated index shows up at once. The memory model stalls each acknowledge by a varying number of cycles, and the request inputs are scrambled during a fetch, which catches a design that drops the address hold or samples its inputs late.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;
  typedef enum logic [4:0] {
    AM_ABS      = 5'd0,
    AM_ABS_X    = 5'd1,
    AM_ABS_Y    = 5'd2,
    AM_LONG     = 5'd3,
    AM_LONG_X   = 5'd4,
    AM_DP       = 5'd5,
    AM_DP_X     = 5'd6,
    AM_DP_Y     = 5'd7,
    AM_DP_IND   = 5'd8,
    AM_DP_IND_Y = 5'd9,
    AM_DP_X_IND = 5'd10,
    AM_DP_LIND  = 5'd11,
    AM_DP_LIND_Y= 5'd12,
    AM_J_IND    = 5'd13,
    AM_J_X_IND  = 5'd14,
    AM_J_LIND   = 5'd15,
    AM_SR_IND_Y = 5'd16
  } amode_e;

  localparam int MODE_W = 5;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/eaddr_idx_sel.sv
module eaddr_idx_sel #(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [WORD_W-1:0] raw,
  input  logic              narrow,
  output logic [WORD_W-1:0] eff
);
  localparam int HI_W = WORD_W - NARROW_W;

  always_comb begin
    if (narrow) eff = {{HI_W{1'b0}}, raw[NARROW_W-1:0]};
    else        eff = raw;
  end
endmodule

// File: rtl/eaddr_decode.sv
module eaddr_decode
  import eaddr_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int WORD_W = 16
) (
  input  logic [MODE_W-1:0]        mode,
  input  logic [BANK_W+WORD_W-1:0] operand,
  input  logic [WORD_W-1:0]        dp_reg,
  input  logic [BANK_W-1:0]        dbank,
  input  logic [BANK_W-1:0]        pbank,
  input  logic [WORD_W-1:0]        x_eff,
  input  logic [WORD_W-1:0]        y_eff,
  input  logic [WORD_W-1:0]        sp_reg,
  input  logic                     ctrl_access,
  output logic [BANK_W+WORD_W-1:0] direct_ea,
  output logic                     needs_ptr,
  output logic [BANK_W+WORD_W-1:0] ptr_base,
  output logic                     ptr_long,
  output logic [BANK_W-1:0]        ptr_bank,
  output logic [WORD_W-1:0]        post_idx
);
  localparam int ADDR_W = BANK_W + WORD_W;
  localparam logic [BANK_W-1:0] ZERO_BANK = '0;

  logic [WORD_W-1:0] op_byte, op_word, dp_sum, dp_sum_x, dp_sum_y, sr_sum, jx_sum;
  logic [ADDR_W-1:0] x_wide, y_wide, abs_data;
  logic [BANK_W-1:0] abs_bank;

  always_comb begin
    op_byte  = {{(WORD_W-BYTE_W){1'b0}}, operand[BYTE_W-1:0]};
    op_word  = operand[WORD_W-1:0];
    dp_sum   = dp_reg + op_byte;
    dp_sum_x = dp_sum + x_eff;
    dp_sum_y = dp_sum + y_eff;
    sr_sum   = sp_reg + op_byte;
    jx_sum   = op_word + x_eff;
    x_wide   = {ZERO_BANK, x_eff};
    y_wide   = {ZERO_BANK, y_eff};
    abs_data = {dbank, op_word};
    abs_bank = ctrl_access ? pbank : dbank;
  end

  always_comb begin
    direct_ea = {abs_bank, op_word};
    needs_ptr = 1'b0;
    ptr_base  = '0;
    ptr_long  = 1'b0;
    ptr_bank  = dbank;
    post_idx  = '0;
    case (amode_e'(mode))
      AM_ABS_X:  direct_ea = abs_data + x_wide;
      AM_ABS_Y:  direct_ea = abs_data + y_wide;
      AM_LONG:   direct_ea = operand;
      AM_LONG_X: direct_ea = operand + x_wide;
      AM_DP:     direct_ea = {ZERO_BANK, dp_sum};
      AM_DP_X:   direct_ea = {ZERO_BANK, dp_sum_x};
      AM_DP_Y:   direct_ea = {ZERO_BANK, dp_sum_y};
      AM_DP_IND: begin
        needs_ptr = 1'b1;
        ptr_base  = {ZERO_BANK, dp_sum};
      end
      AM_DP_IND_Y: begin
        needs_ptr = 1'b1;
        ptr_base  = {ZERO_BANK, dp_sum};
        post_idx  = y_eff;
      end
      AM_DP_X_IND: begin
        needs_ptr = 1'b1;
        ptr_base  = {ZERO_BANK, dp_sum_x};
      end
      AM_DP_LIND: begin
        needs_ptr = 1'b1;
        ptr_long  = 1'b1;
        ptr_base  = {ZERO_BANK, dp_sum};
      end
      AM_DP_LIND_Y: begin
        needs_ptr = 1'b1;
        ptr_long  = 1'b1;
        ptr_base  = {ZERO_BANK, dp_sum};
        post_idx  = y_eff;
      end
      AM_J_IND: begin
        needs_ptr = 1'b1;
        ptr_base  = {ZERO_BANK, op_word};
        ptr_bank  = pbank;
      end
      AM_J_X_IND: begin
        needs_ptr = 1'b1;
        ptr_base  = {pbank, jx_sum};
        ptr_bank  = pbank;
      end
      AM_J_LIND: begin
        needs_ptr = 1'b1;
        ptr_long  = 1'b1;
        ptr_base  = {ZERO_BANK, op_word};
      end
      AM_SR_IND_Y: begin
        needs_ptr = 1'b1;
        ptr_base  = {ZERO_BANK, sr_sum};
        post_idx  = y_eff;
      end
      default: direct_ea = {abs_bank, op_word};
    endcase
  end
endmodule

// File: rtl/eaddr_ptr_fetch.sv
module eaddr_ptr_fetch
  import eaddr_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [BANK_W+WORD_W-1:0] base,
  input  logic                     long_ptr,
  input  logic                     rd_ack,
  input  logic [BYTE_W-1:0]        rd_data,
  output logic                     rd_req,
  output logic [BANK_W+WORD_W-1:0] rd_addr,
  output logic                     busy,
  output logic                     last_ack,
  output logic [BANK_W+WORD_W-1:0] ptr_val
);
  localparam int ADDR_W = BANK_W + WORD_W;
  localparam int CNT_W  = 2;

  logic              busy_q, long_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BANK_W-1:0] bank_q;
  logic [WORD_W-1:0] off_q;
  logic [BYTE_W-1:0] byte0_q, byte1_q;
  logic              last_byte;

  always_comb begin
    busy      = busy_q;
    rd_req    = busy_q;
    rd_addr   = {bank_q, off_q + WORD_W'(cnt_q)};
    last_byte = long_q ? (cnt_q == CNT_W'(2)) : (cnt_q == CNT_W'(1));
    last_ack  = busy_q & rd_ack & last_byte;
    if (long_q) ptr_val = {rd_data, byte1_q, byte0_q};
    else        ptr_val = {{(ADDR_W-2*BYTE_W){1'b0}}, rd_data, byte0_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      long_q  <= 1'b0;
      cnt_q   <= '0;
      bank_q  <= '0;
      off_q   <= '0;
      byte0_q <= '0;
      byte1_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      long_q <= long_ptr;
      cnt_q  <= '0;
      bank_q <= base[ADDR_W-1:WORD_W];
      off_q  <= base[WORD_W-1:0];
    end else if (busy_q && rd_ack) begin
      if (last_byte) busy_q <= 1'b0;
      else           cnt_q  <= cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(0)) byte0_q <= rd_data;
      if (cnt_q == CNT_W'(1)) byte1_q <= rd_data;
    end
  end
endmodule

// File: rtl/eaddr_gen.sv
module eaddr_gen
  import eaddr_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [4:0]               mode,
  input  logic [BANK_W+WORD_W-1:0] operand,
  input  logic [WORD_W-1:0]        dp_reg,
  input  logic [BANK_W-1:0]        dbank,
  input  logic [BANK_W-1:0]        pbank,
  input  logic [WORD_W-1:0]        x_reg,
  input  logic [WORD_W-1:0]        y_reg,
  input  logic [WORD_W-1:0]        sp_reg,
  input  logic                     idx_narrow,
  input  logic                     ctrl_access,
  output logic                     rd_req,
  output logic [BANK_W+WORD_W-1:0] rd_addr,
  input  logic                     rd_ack,
  input  logic [7:0]               rd_data,
  output logic [BANK_W+WORD_W-1:0] ea,
  output logic                     done
);
  localparam int ADDR_W = BANK_W + WORD_W;
  localparam int N_IDX  = 2;

  logic [WORD_W-1:0] idx_raw [N_IDX];
  logic [WORD_W-1:0] idx_eff [N_IDX];

  assign idx_raw[0] = x_reg;
  assign idx_raw[1] = y_reg;

  for (genvar gi = 0; gi < N_IDX; gi++) begin : g_idx
    eaddr_idx_sel #(.WORD_W(WORD_W), .NARROW_W(BYTE_W)) u_sel (
      .raw    (idx_raw[gi]),
      .narrow (idx_narrow),
      .eff    (idx_eff[gi])
    );
  end

  logic [ADDR_W-1:0] direct_ea, ptr_base, ptr_val, final_ea;
  logic              needs_ptr, ptr_long, busy, last_ack, accept;
  logic [BANK_W-1:0] ptr_bank;
  logic [WORD_W-1:0] post_idx;

  eaddr_decode #(.BANK_W(BANK_W), .WORD_W(WORD_W)) u_dec (
    .mode        (mode),
    .operand     (operand),
    .dp_reg      (dp_reg),
    .dbank       (dbank),
    .pbank       (pbank),
    .x_eff       (idx_eff[0]),
    .y_eff       (idx_eff[1]),
    .sp_reg      (sp_reg),
    .ctrl_access (ctrl_access),
    .direct_ea   (direct_ea),
    .needs_ptr   (needs_ptr),
    .ptr_base    (ptr_base),
    .ptr_long    (ptr_long),
    .ptr_bank    (ptr_bank),
    .post_idx    (post_idx)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  eaddr_ptr_fetch #(.BANK_W(BANK_W), .WORD_W(WORD_W)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept && needs_ptr),
    .base     (ptr_base),
    .long_ptr (ptr_long),
    .rd_ack   (rd_ack),
    .rd_data  (rd_data),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .busy     (busy),
    .last_ack (last_ack),
    .ptr_val  (ptr_val)
  );

  logic              long_q, done_q;
  logic [BANK_W-1:0] bank_q;
  logic [WORD_W-1:0] post_q;
  logic [ADDR_W-1:0] ea_q;

  always_comb begin
    if (long_q) final_ea = ptr_val + {{BANK_W{1'b0}}, post_q};
    else        final_ea = {bank_q, ptr_val[WORD_W-1:0]} + {{BANK_W{1'b0}}, post_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      long_q <= 1'b0;
      done_q <= 1'b0;
      bank_q <= '0;
      post_q <= '0;
      ea_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (needs_ptr) begin
          long_q <= ptr_long;
          bank_q <= ptr_bank;
          post_q <= post_idx;
        end else begin
          ea_q   <= direct_ea;
          done_q <= 1'b1;
        end
      end else if (last_ack) begin
        ea_q   <= final_ea;
        done_q <= 1'b1;
      end
    end
  end

  assign ea   = ea_q;
  assign done = done_q;
endmodule

// File: rtl/eaddr_gen_chk.sv
module eaddr_gen_chk #(
  parameter int BANK_W = 8,
  parameter int WORD_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [4:0]               mode,
  input logic                     rd_req,
  input logic [BANK_W+WORD_W-1:0] rd_addr,
  input logic                     rd_ack,
  input logic                     done
);
  localparam int ADDR_W = BANK_W + WORD_W;

  logic take, ind_mode;
  assign take     = req_valid && req_ready;
  assign ind_mode = (mode >= 5'd8) && (mode <= 5'd16);

  AST_FETCH_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !req_ready); // R12

  AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))); // R10

  AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack) |=> (!rd_req ||
      (rd_addr[ADDR_W-1:WORD_W] == $past(rd_addr[ADDR_W-1:WORD_W]) &&
       rd_addr[WORD_W-1:0] == $past(rd_addr[WORD_W-1:0]) + WORD_W'(1)))); // R10

  AST_DIRECT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ind_mode) |=> done); // R1

  AST_INDIRECT_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ind_mode) |=> (rd_req && !done)); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !take) |=> !done); // R11

  AST_DONE_NOT_READING: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req); // R11
endmodule

bind eaddr_gen eaddr_gen_chk #(.BANK_W(BANK_W), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mode      (mode),
  .rd_req    (rd_req),
  .rd_addr   (rd_addr),
  .rd_ack    (rd_ack),
  .done      (done)
);

// File: tb/eaddr_gen_tb.sv
module eaddr_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  mode = '0;
  logic [23:0] operand = '0;
  logic [15:0] dp_reg = '0, x_reg = '0, y_reg = '0, sp_reg = '0;
  logic [7:0]  dbank = '0, pbank = '0;
  logic        idx_narrow = 1'b0, ctrl_access = 1'b0;
  logic        rd_req;
  logic [23:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [7:0]  rd_data = '0;
  logic [23:0] ea;
  logic        done;

  int n_cmp = 0;
  int n_bad = 0;
  int stall_seed = 0;
  bit finished = 0;
  int lcg = 32'h1234567;

  always #(CLK_PERIOD/2) clk = ~clk;

  eaddr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mode(mode), .operand(operand), .dp_reg(dp_reg), .dbank(dbank), .pbank(pbank),
    .x_reg(x_reg), .y_reg(y_reg), .sp_reg(sp_reg), .idx_narrow(idx_narrow),
    .ctrl_access(ctrl_access), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .ea(ea), .done(done)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    int v;
    v = int'(a[7:0]) * 7 + int'(a[15:8]) * 13 + int'(a[23:16]) * 29 + 90;
    return v[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int next_rand();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 8) & 32'h00FF_FFFF;
  endfunction

  // Behavioural model of one request; pointer addresses come back in a queue.
  task automatic model(input int m, input int op, input int d, input int db,
                       input int pb, input int x, input int y, input int s,
                       input bit n, input bit c,
                       output int exp_ea, output int addrs[$]);
    int xi, yi, pbase_bank, pbase_off, nb, pre_bank, post, ptr, ob;
    xi = n ? (x & 'hFF) : x;
    yi = n ? (y & 'hFF) : y;
    ob = op & 'hFF;
    nb = 0; post = 0; pre_bank = db; pbase_bank = 0; pbase_off = 0;
    addrs = {};
    exp_ea = ((c ? pb : db) << 16) | (op & 'hFFFF);
    case (m)
      1: exp_ea = (((db << 16) | (op & 'hFFFF)) + xi) & 'hFFFFFF;
      2: exp_ea = (((db << 16) | (op & 'hFFFF)) + yi) & 'hFFFFFF;
      3: exp_ea = op & 'hFFFFFF;
      4: exp_ea = (op + xi) & 'hFFFFFF;
      5: exp_ea = (d + ob) & 'hFFFF;
      6: exp_ea = (d + ob + xi) & 'hFFFF;
      7: exp_ea = (d + ob + yi) & 'hFFFF;
      8:  begin nb = 2; pbase_off = d + ob; end
      9:  begin nb = 2; pbase_off = d + ob; post = yi; end
      10: begin nb = 2; pbase_off = d + ob + xi; end
      11: begin nb = 3; pbase_off = d + ob; end
      12: begin nb = 3; pbase_off = d + ob; post = yi; end
      13: begin nb = 2; pbase_off = op; pre_bank = pb; end
      14: begin nb = 2; pbase_bank = pb; pbase_off = op + xi; pre_bank = pb; end
      15: begin nb = 3; pbase_off = op; end
      16: begin nb = 2; pbase_off = s + ob; post = yi; end
      default: ;
    endcase
    if (nb > 0) begin
      ptr = 0;
      for (int i = 0; i < nb; i++) begin
        int a;
        a = (pbase_bank << 16) | ((pbase_off + i) & 'hFFFF);
        addrs.push_back(a);
        ptr = ptr | (int'(mem_byte(a[23:0])) << (8 * i));
      end
      if (nb == 3) exp_ea = (ptr + post) & 'hFFFFFF;
      else         exp_ea = (((pre_bank << 16) | ptr) + post) & 'hFFFFFF;
    end
  endtask

  task automatic run_tx(input int m, input int op, input int d, input int db,
                        input int pb, input int x, input int y, input int s,
                        input bit n, input bit c, input string req,
                        input bit scramble);
    int exp_ea;
    int addrs[$];
    model(m, op, d, db, pb, x, y, s, n, c, exp_ea, addrs);
    @(negedge clk);
    mode = 5'(m); operand = 24'(op); dp_reg = 16'(d); dbank = 8'(db);
    pbank = 8'(pb); x_reg = 16'(x); y_reg = 16'(y); sp_reg = 16'(s);
    idx_narrow = n; ctrl_access = c; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R12 ready before request", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin
      mode = 5'd3; operand = ~operand; dp_reg = ~dp_reg; dbank = ~dbank;
      pbank = ~pbank; x_reg = ~x_reg; y_reg = ~y_reg; sp_reg = ~sp_reg;
      idx_narrow = ~idx_narrow; req_valid = 1'b1;
    end
    foreach (addrs[i]) begin
      int stall;
      stall = (stall_seed + i) % 3;
      for (int k = 0; k < stall; k++) begin
        chk(rd_req == 1'b1, {req, " R10 read request held"}, 32'(rd_req), 1);
        chk(rd_addr == 24'(addrs[i]), {req, " R10 pointer address"}, 32'(rd_addr), addrs[i]);
        chk(done == 1'b0, {req, " R11 no early done"}, 32'(done), 0);
        chk(req_ready == 1'b0, "R12 ready low during fetch", 32'(req_ready), 0);
        @(negedge clk);
      end
      chk(rd_req == 1'b1, {req, " R10 read request"}, 32'(rd_req), 1);
      chk(rd_addr == 24'(addrs[i]), {req, " R10 pointer address"}, 32'(rd_addr), addrs[i]);
      chk(req_ready == 1'b0, "R12 ready low during fetch", 32'(req_ready), 0);
      rd_ack = 1'b1;
      rd_data = mem_byte(rd_addr);
      @(negedge clk);
      rd_ack = 1'b0;
      rd_data = 8'h00;
    end
    req_valid = 1'b0;
    stall_seed++;
    chk(done == 1'b1, {req, " R11 done pulse"}, 32'(done), 1);
    chk(ea == 24'(exp_ea), {req, " effective address"}, 32'(ea), exp_ea);
    chk(rd_req == 1'b0, {req, " R11 no read at done"}, 32'(rd_req), 0);
    @(negedge clk);
    chk(done == 1'b0, {req, " R11 single-cycle done"}, 32'(done), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1, "R13 reset ready", 32'(req_ready), 1);
    chk(done == 1'b0, "R13 reset done", 32'(done), 0);
    chk(rd_req == 1'b0, "R13 reset read", 32'(rd_req), 0);
    rst_n = 1'b1;

    // R1 absolute, data versus control bank
    run_tx(0, 'h00ABCD, 0, 'h12, 'h7E, 0, 0, 0, 0, 0, "R1 abs data", 0);
    run_tx(0, 'h00ABCD, 0, 'h12, 'h7E, 0, 0, 0, 0, 1, "R1 abs control", 0);
    // R2 long and long,X with 24-bit wrap
    run_tx(3, 'hC0FFEE, 0, 0, 0, 0, 0, 0, 0, 0, "R2 long", 0);
    run_tx(4, 'hFFFFFF, 0, 0, 0, 1, 0, 0, 0, 0, "R2 long X wrap", 0);
    run_tx(4, 'h100000, 0, 0, 0, 'h1234, 0, 0, 1, 0, "R4 long X narrow", 0);
    // R3 indexed absolute carries into the bank
    run_tx(1, 'h00FFFF, 0, 'h12, 0, 2, 0, 0, 0, 0, "R3 abs X carry", 0);
    run_tx(2, 'h00FF80, 0, 'h12, 0, 0, 'hAB90, 0, 1, 0, "R4 abs Y narrow", 0);
    run_tx(2, 'h00FF80, 0, 'h12, 0, 0, 'hAB90, 0, 0, 0, "R3 abs Y wide", 0);
    // R5 direct page wraps inside bank zero
    run_tx(5, 'h20, 'hFFF0, 'h33, 0, 0, 0, 0, 0, 0, "R5 dp wrap", 0);
    run_tx(6, 'h10, 'h0200, 'h33, 0, 'h0105, 0, 0, 0, 0, "R5 dp X", 0);
    run_tx(7, 'h10, 'hFF00, 'h33, 0, 0, 'h12F5, 0, 1, 0, "R4 dp Y narrow", 0);
    // R6 16-bit direct-page pointers
    run_tx(8, 'h40, 'h1200, 'h7F, 0, 0, 0, 0, 0, 0, "R6 dp ind", 0);
    run_tx(9, 'h00, 'hFFFF, 'h7F, 0, 0, 'hFFFF, 0, 0, 0, "R6 dp ind Y ptr wrap", 0);
    run_tx(10, 'h04, 'h0100, 'h05, 0, 'h0300, 0, 0, 0, 0, "R6 dp X ind", 0);
    // R7 24-bit direct-page pointers
    run_tx(11, 'h22, 'h4400, 0, 0, 0, 0, 0, 0, 0, "R7 dp long ind", 0);
    run_tx(12, 'hFF, 'hFF00, 0, 0, 0, 'h89AB, 0, 0, 0, "R7 dp long ind Y", 0);
    // R8 jump-indirect forms
    run_tx(13, 'h001234, 0, 'h11, 'h7E, 0, 0, 0, 0, 1, "R8 jmp ind", 0);
    run_tx(14, 'h00FFFE, 0, 'h11, 'h7E, 3, 0, 0, 0, 1, "R8 jmp X ind bank", 0);
    run_tx(15, 'h00ABCD, 0, 'h11, 'h7E, 0, 0, 0, 0, 1, "R8 jmp long ind", 0);
    // R9 stack relative indirect indexed
    run_tx(16, 'h03, 0, 'h22, 0, 0, 'h5510, 'h01FD, 1, 0, "R9 sr ind Y", 0);
    run_tx(16, 'h05, 0, 'hFF, 0, 0, 'hFFF0, 'hFFFE, 0, 0, "R9 sr ind Y carry", 0);
    // R12 inputs changed and request held while fetching
    run_tx(12, 'h10, 'h0800, 'h40, 'h41, 0, 'h0022, 0, 0, 0, "R12 scrambled inputs", 1);
    run_tx(9, 'h30, 'h0500, 'h40, 'h41, 0, 'h0101, 0, 1, 0, "R12 scrambled inputs", 1);

    // Mixed sweep over all codes
    for (int t = 0; t < 60; t++) begin
      int m;
      m = t % 17;
      run_tx(m, next_rand(), next_rand() & 'hFFFF, next_rand() & 'hFF,
             next_rand() & 'hFF, next_rand() & 'hFFFF, next_rand() & 'hFFFF,
             next_rand() & 'hFFFF, bit'(t / 17 % 2), bit'(t % 2), "R1-sweep", 0);
    end
    finish_run();
  end
endmodule